// File: doc/BRIEF.md
# Scalar Floating-Point Conditional Select Unit

This block decodes and executes a single scalar floating-point conditional-select instruction carried in a 32-bit word. It checks the fixed opcode bits, pulls out the operand precision, two source register indices, a destination index and a 4-bit condition code. It then tests that code against the four arithmetic flags (negative, zero, carry, overflow). The value of one of the two sources is written into the destination of a local 32-entry, 64-bit register file. No arithmetic is performed: the operand is moved whole, cut to the chosen precision of 16, 32 or 64 bits, and the upper destination bits are cleared.

Every issue completes in exactly one clock. A done pulse appears on the cycle after the issue strobe, and the register write is committed on that same edge. A side write port preloads or overwrites registers, and a combinational read port shows any register's contents. Two flags report whether the word was not this instruction at all or was this instruction with an illegal precision. A configuration input enables half precision. A second input requests data-independent timing, which the fixed latency already meets in every mode.

Top module: `fp_csel_unit`

## Requirements
- R1: While reset is asserted and after it is released, `done`, `undef` and `unrecog` are low and all 32 registers read as zero.
- R2: A word is recognised only if bits [31:24] = 8'b00011110, bit [21] = 1 and bits [11:10] = 2'b11. Any other word sets `unrecog` with `done` and writes no register.
- R3: Precision field bits [23:22] = 00 selects 32-bit operands: the destination gets the low 32 bits of the chosen source, with bits [63:32] written as zero.
- R4: Precision field 01 selects 64-bit operands: the destination gets the whole chosen source.
- R5: Precision field 11 with `half_en` high selects 16-bit operands: the destination gets the low 16 bits of the chosen source, with bits [63:16] written as zero.
- R6: Precision field 10 sets `undef` with `done` and leaves every register unchanged.
- R7: Precision field 11 with `half_en` low sets `undef` with `done` and leaves every register unchanged.
- R8: The condition is in bits [15:12] and is tested against `nzcv` = {N,Z,C,V}. Bits [3:1] pick the base test: 000 Z, 001 C, 010 N, 011 V, 100 C and not Z, 101 N equals V, 110 not Z and N equals V. Bit [0] = 1 inverts the result. If the condition holds, the destination (bits [4:0]) receives the first source (bits [9:5]); otherwise it receives the second source (bits [20:16]).
- R9: Condition codes 1110 and 1111 always hold.
- R10: `done` is high for exactly the one cycle after each cycle with `issue` high, and the register write is visible on `rd_data` from that cycle. This latency does not depend on `const_time`, the flags or the register contents.
- R11: If a preload write and an executed write hit the same register in the same cycle, the executed result is kept.
- R12: When the destination equals a source, the value selected is the register's content from before the instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue | input | 1 | Execute `instr` this cycle |
| instr | input | 32 | Instruction word |
| nzcv | input | 4 | Flags {N,Z,C,V} |
| half_en | input | 1 | Enables 16-bit precision |
| const_time | input | 1 | Data-independent timing request |
| wr_en | input | 1 | Preload write enable |
| wr_addr | input | 5 | Preload register index |
| wr_data | input | 64 | Preload data |
| rd_addr | input | 5 | Observation read index |
| rd_data | output | 64 | Register contents at `rd_addr` (combinational) |
| done | output | 1 | Completion pulse, one cycle after issue |
| undef | output | 1 | Illegal precision, valid with `done` |
| unrecog | output | 1 | Word is not this instruction, valid with `done` |

## Verification
All three status outputs and the register write come due on the first rising edge after the cycle in which `issue` is high. The bench drives inputs on the falling edge and checks `done`, `undef`, `unrecog` and the destination register on the next falling edge, half a cycle after that rising edge. It checks `done` once more on the falling edge after that, to prove the pulse lasts a single cycle. Preload writes use the same half-cycle timing, and `rd_data` is read combinationally after a short settle delay inside the sample cycle.

// File: rtl/fp_csel_unit.sv
module fp_csel_unit #(
  parameter int NREG = 32,
  parameter int DW   = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic [31:0]   instr,
  input  logic [3:0]    nzcv,
  input  logic          half_en,
  input  logic          const_time,
  input  logic          wr_en,
  input  logic [4:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [4:0]    rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          done,
  output logic          undef,
  output logic          unrecog
);

  logic [DW-1:0] rf [NREG];

  wire [1:0] ptype  = instr[23:22];
  wire [4:0] src_b  = instr[20:16];
  wire [3:0] cc     = instr[15:12];
  wire [4:0] src_a  = instr[9:5];
  wire [4:0] dst    = instr[4:0];

  wire flg_n = nzcv[3];
  wire flg_z = nzcv[2];
  wire flg_c = nzcv[1];
  wire flg_v = nzcv[0];

  wire fixed_ok  = (instr[31:24] == 8'b0001_1110) && instr[21] && (instr[11:10] == 2'b11);
  wire bad_prec  = (ptype == 2'b10) || ((ptype == 2'b11) && !half_en);
  wire exec_wr   = issue && fixed_ok && !bad_prec;

  logic base_hit, cond_ok;
  always_comb begin
    case (cc[3:1])
      3'd0:    base_hit = flg_z;
      3'd1:    base_hit = flg_c;
      3'd2:    base_hit = flg_n;
      3'd3:    base_hit = flg_v;
      3'd4:    base_hit = flg_c && !flg_z;
      3'd5:    base_hit = (flg_n == flg_v);
      3'd6:    base_hit = !flg_z && (flg_n == flg_v);
      default: base_hit = 1'b1;
    endcase
    cond_ok = (cc[0] && (cc[3:1] != 3'd7)) ? !base_hit : base_hit;
  end

  wire [DW-1:0] picked = cond_ok ? rf[src_a] : rf[src_b];

  logic [DW-1:0] result;
  always_comb begin
    case (ptype)
      2'b00:   result = {{(DW-32){1'b0}}, picked[31:0]};
      2'b11:   result = {{(DW-16){1'b0}}, picked[15:0]};
      default: result = picked;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else begin
      if (wr_en)   rf[wr_addr] <= wr_data;
      if (exec_wr) rf[dst]     <= result;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done    <= 1'b0;
      undef   <= 1'b0;
      unrecog <= 1'b0;
    end else begin
      done    <= issue;
      unrecog <= issue && !fixed_ok;
      undef   <= issue && fixed_ok && bad_prec;
    end
  end

  assign rd_data = rf[rd_addr];

  a_r10_done_follows_issue: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> done);
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |=> !done);
  a_r10_const_time_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && const_time) |=> done);
  a_r2_unrecog_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    unrecog |-> (done && !undef));
  a_r6_undef_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    undef |-> done);
  a_r6_undef_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && fixed_ok && (ptype == 2'b10) && !wr_en) |=> $stable(rf[$past(dst)]));
  a_r3_upper_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && fixed_ok && (ptype == 2'b00)) |=> (rf[$past(dst)][DW-1:32] == '0));

endmodule

// File: tb/sim_fp_csel_unit.sv
module sim_fp_csel_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue = 1'b0;
  logic [31:0] instr = '0;
  logic [3:0]  nzcv = '0;
  logic        half_en = 1'b0;
  logic        const_time = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [63:0] wr_data = '0;
  logic [4:0]  rd_addr = '0;
  logic [63:0] rd_data;
  logic        done, undef, unrecog;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  fp_csel_unit u0 (
    .clk(clk), .rst_n(rst_n), .issue(issue), .instr(instr), .nzcv(nzcv),
    .half_en(half_en), .const_time(const_time), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .done(done),
    .undef(undef), .unrecog(unrecog)
  );

  // {ptype, cond, nzcv, expected hold}
  localparam logic [10:0] VEC [19] = '{
    {2'b00, 4'b0000, 4'b0100, 1'b1},
    {2'b01, 4'b0000, 4'b0000, 1'b0},
    {2'b11, 4'b0001, 4'b0100, 1'b0},
    {2'b00, 4'b0010, 4'b0010, 1'b1},
    {2'b01, 4'b0011, 4'b0010, 1'b0},
    {2'b11, 4'b0100, 4'b1000, 1'b1},
    {2'b00, 4'b0101, 4'b1000, 1'b0},
    {2'b01, 4'b0110, 4'b0001, 1'b1},
    {2'b11, 4'b0111, 4'b0000, 1'b1},
    {2'b00, 4'b1000, 4'b0010, 1'b1},
    {2'b01, 4'b1000, 4'b0110, 1'b0},
    {2'b11, 4'b1001, 4'b0110, 1'b1},
    {2'b00, 4'b1010, 4'b1001, 1'b1},
    {2'b01, 4'b1011, 4'b1000, 1'b1},
    {2'b11, 4'b1100, 4'b0000, 1'b1},
    {2'b00, 4'b1100, 4'b0100, 1'b0},
    {2'b01, 4'b1101, 4'b1000, 1'b1},
    {2'b11, 4'b1110, 4'b0000, 1'b1},
    {2'b00, 4'b1111, 4'b0101, 1'b1}
  };

  function automatic logic [31:0] mk(input logic [1:0] pt, input logic [4:0] m,
                                     input logic [3:0] c, input logic [4:0] n, input logic [4:0] d);
    return {8'b0001_1110, pt, 1'b1, m, c, 2'b11, n, d};
  endfunction

  function automatic logic [63:0] cut(input logic [1:0] pt, input logic [63:0] v);
    if (pt == 2'b00) return {32'h0, v[31:0]};
    if (pt == 2'b11) return {48'h0, v[15:0]};
    return v;
  endfunction

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic preload(input logic [4:0] a, input logic [63:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic peek(input logic [4:0] a, output logic [63:0] v);
    rd_addr = a;
    #0.5;
    v = rd_data;
  endtask

  task automatic run(input logic [31:0] w, input logic [3:0] f);
    @(negedge clk);
    instr = w; nzcv = f; issue = 1'b1;
    @(negedge clk);
    issue = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] v, va, vb, exp;
    repeat (3) @(negedge clk);
    check({63'h0, done}, 64'h0, "R1 done in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check({61'h0, done, undef, unrecog}, 64'h0, "R1 status after reset");
    for (int r = 0; r < 32; r++) begin
      peek(r[4:0], v);
      check(v, 64'h0, "R1 register cleared");
    end

    half_en = 1'b1;
    for (int i = 0; i < 19; i++) begin
      logic [1:0] pt; logic [3:0] cd; logic [3:0] fl; logic hd;
      logic [4:0] n, m, d;
      {pt, cd, fl, hd} = VEC[i];
      n = 5'(i % 8 + 1); m = 5'(i % 8 + 9); d = 5'(i % 8 + 20);
      va = 64'hA5A5_1234_5678_9ABC ^ 64'(i);
      vb = 64'h0F0F_CAFE_BEEF_4321 + 64'(i);
      const_time = i[0];
      preload(n, va); preload(m, vb); preload(d, '1);
      run(mk(pt, m, cd, n, d), fl);
      check({63'h0, done}, 64'h1, "R10 done one cycle after issue");
      check({62'h0, undef, unrecog}, 64'h0, "R8 no error flags");
      peek(d, v);
      exp = cut(pt, hd ? va : vb);
      if (pt == 2'b00) check(v, exp, "R3 32-bit select R8 R9");
      else if (pt == 2'b01) check(v, exp, "R4 64-bit select R8 R9");
      else check(v, exp, "R5 16-bit select R8 R9");
      @(negedge clk);
      check({63'h0, done}, 64'h0, "R10 done single pulse");
    end

    preload(5'd3, 64'h1111_2222_3333_4444);
    run(mk(2'b01, 5'd4, 4'b1110, 5'd5, 5'd3) ^ 32'h8000_0000, 4'b0);
    check({61'h0, done, undef, unrecog}, 64'b101, "R2 bad opcode flagged");
    peek(5'd3, v);
    check(v, 64'h1111_2222_3333_4444, "R2 no write");
    run(mk(2'b01, 5'd4, 4'b1110, 5'd5, 5'd3) & ~32'h0000_0800, 4'b0);
    check({61'h0, done, undef, unrecog}, 64'b101, "R2 bad bit 11 flagged");

    run(mk(2'b10, 5'd4, 4'b1110, 5'd5, 5'd3), 4'b0);
    check({61'h0, done, undef, unrecog}, 64'b110, "R6 precision 10 undefined");
    peek(5'd3, v);
    check(v, 64'h1111_2222_3333_4444, "R6 no write");

    half_en = 1'b0;
    run(mk(2'b11, 5'd4, 4'b1110, 5'd5, 5'd3), 4'b0);
    check({61'h0, done, undef, unrecog}, 64'b110, "R7 half disabled undefined");
    peek(5'd3, v);
    check(v, 64'h1111_2222_3333_4444, "R7 no write");
    half_en = 1'b1;

    preload(5'd6, 64'hDEAD_BEEF_0000_0001);
    @(negedge clk);
    instr = mk(2'b01, 5'd3, 4'b1110, 5'd6, 5'd7); nzcv = 4'b0; issue = 1'b1;
    wr_en = 1'b1; wr_addr = 5'd7; wr_data = 64'h5555_5555_5555_5555;
    @(negedge clk);
    issue = 1'b0; wr_en = 1'b0;
    peek(5'd7, v);
    check(v, 64'hDEAD_BEEF_0000_0001, "R11 executed write wins");

    preload(5'd8, 64'h0123_4567_89AB_CDEF);
    preload(5'd9, 64'hFEDC_BA98_7654_3210);
    run(mk(2'b00, 5'd9, 4'b0000, 5'd8, 5'd8), 4'b0000);
    peek(5'd8, v);
    check(v, 64'h0000_0000_7654_3210, "R12 alias destination takes old source");

    const_time = 1'b1;
    @(negedge clk);
    instr = mk(2'b01, 5'd9, 4'b0001, 5'd8, 5'd10); nzcv = 4'b1111; issue = 1'b1;
    @(negedge clk);
    check({63'h0, done}, 64'h1, "R10 back-to-back first done");
    instr = mk(2'b01, 5'd8, 4'b0000, 5'd9, 5'd11); nzcv = 4'b0000;
    @(negedge clk);
    issue = 1'b0;
    check({63'h0, done}, 64'h1, "R10 back-to-back second done");
    peek(5'd11, v);
    check(v, 64'h0000_0000_7654_3210, "R8 EQ false takes second source");
    @(negedge clk);
    check({63'h0, done}, 64'h0, "R10 done drops");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule